// File: doc/BRIEF.md
# I2S/TDM Transmit Serializer

This block turns parallel audio words into a serial audio stream. As master it generates a bit clock from the system clock, a word-select line and a serial data line. One frame holds between 1 and 16 slots. Each slot carries one sample of 16, 24 or 32 bits. A 24-bit sample can be stretched to a 32-bit slot, with the sample placed at the start or at the end of the slot. Samples arrive on a valid/ready stream. The block pulls a word at the start of each slot that needs one.

Per-slot enables silence individual slots. A skip option decides whether the input stream also carries words for the silenced slots, which are then read and thrown away. Mono mode uses a two-slot frame that is fed by one word per frame. The unused channel either repeats that word or sends a constant.

Configuration inputs must be held steady while `enable` is high. Dropping `enable` returns the block to the start of a frame.

Top module: `i2s_tx_serializer`

## Requirements
- R1: While `rstN` is low, `bckOut`, `wsOut`, `sdOut`, `underflow` and `inReady` are all 0.
- R2: While enabled, `bckOut` toggles every BCK_HALF clocks, so one bit lasts 2*BCK_HALF clocks. `wsOut` and `sdOut` change only in the cycle in which `bckOut` falls. While `enable` is low, `bckOut` is 0 on the next cycle.
- R3: `wsOut` equals `cfgWsPol` for slots s with 2*s < slot count, and its inverse for the other slots. `sdOut` lags `wsOut` by one bit period, so WS changes one bit before the first bit of a slot. The first bit period after enabling sends 0.
- R4: `cfgWidth` sets the sample width: 0 gives 16, 1 gives 24, and 2 or 3 gives 32. The slot length equals the sample width, except that width 24 with `cfgFill24`=1 uses 32-bit slots. Only the low bits of a word, up to the sample width, are sent.
- R5: `cfgLsbFirst`=0 sends the sample MSB first. `cfgLsbFirst`=1 sends it LSB first.
- R6: In a slot longer than the sample, `cfgLeftAlign`=1 sends the sample first and then zeros. `cfgLeftAlign`=0 sends zeros first and then the sample.
- R7: A frame has `cfgSlotLast`+1 slots. Slot s is enabled by `cfgSlotEn` bit s. A disabled slot sends zeros.
- R8: With `cfgSkipMask`=0 only enabled slots take an input word. With `cfgSkipMask`=1 every slot takes a word, and the words for disabled slots are dropped.
- R9: With `cfgMono`=1 the frame has 2 slots and takes one word, at the start of slot 0. The word goes to slot 0 when `cfgMonoFirst`=1, and to slot 1 otherwise.
- R10: In mono mode, the slot that does not carry the word repeats it when `cfgMonoEqual`=1. When `cfgMonoEqual`=0 it sends `cfgConst`, trimmed to the sample width like a word.
- R11: If a word is due and `inValid` is low, the slot sends zeros (or the mono word is taken as 0), and `underflow` is high for one cycle, one cycle later.
- R12: `inReady` is high for a single cycle at the start of each slot that takes a word. A word is accepted only when `inValid` and `inReady` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run the serializer; low returns it to frame start |
| cfgWidth | input | 2 | Sample width code |
| cfgFill24 | input | 1 | Use 32-bit slots for 24-bit samples |
| cfgLeftAlign | input | 1 | Place the sample at the start of the slot |
| cfgLsbFirst | input | 1 | Send the least significant bit first |
| cfgWsPol | input | 1 | WS level during the left half of the frame |
| cfgSlotLast | input | SLOT_W (4) | Slot count minus one |
| cfgSlotEn | input | MAX_SLOTS (16) | Per-slot enable |
| cfgSkipMask | input | 1 | Input also carries words for disabled slots |
| cfgMono | input | 1 | Mono mode |
| cfgMonoFirst | input | 1 | Mono word goes to slot 0 |
| cfgMonoEqual | input | 1 | Other mono slot repeats the word |
| cfgConst | input | DATA_W (32) | Constant for the other mono slot |
| inValid | input | 1 | Input word valid |
| inData | input | DATA_W (32) | Input word |
| inReady | output | 1 | Word accepted this cycle if valid |
| bckOut | output | 1 | Bit clock |
| wsOut | output | 1 | Word select |
| sdOut | output | 1 | Serial data |
| underflow | output | 1 | Pulse: a word was due but absent |

## Verification
The bench compares captured bit streams against a frame model built from the requirements. It covers these corner cases:
- 24-bit samples in padded slots, checked with both alignments and without padding. A wrong shift shows up as the sample leaking into the pad bits.
- A TDM frame with a silenced middle slot, run with and without skip mode. A design that got the word accounting wrong would shift every later slot's data by one word.
- Both mono slot orders, once with a repeated word and once with the constant. Taking the word at the wrong slot would put stale data in the first channel.
- An empty input stream, which must produce silence, exactly one underflow pulse per due word, and no stray accepted words.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;

  typedef enum logic [1:0] {SRC_ZERO, SRC_INPUT, SRC_HELD, SRC_CONST} srcSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    flush;
    logic    bitTick;
    logic    loadSlot;
    logic    capHeld;
    logic    wordOk;
    srcSel_e src;
  } ctrlStrobe_t;

  function automatic logic [5:0] sampleBits(input logic [1:0] widthCode);
    case (widthCode)
      2'b00:   return 6'd16;
      2'b01:   return 6'd24;
      default: return 6'd32;
    endcase
  endfunction

  function automatic logic [5:0] slotBits(input logic [1:0] widthCode, input logic fill);
    if (widthCode == 2'b00)              return 6'd16;
    else if (widthCode == 2'b01 && !fill) return 6'd24;
    else                                  return 6'd32;
  endfunction

endpackage

// File: rtl/i2s_tx_ctrl.sv
module i2s_tx_ctrl
  import i2s_tx_pkg::*;
#(
  parameter int BCK_HALF  = 2,
  parameter int MAX_SLOTS = 16,
  localparam int SLOT_W   = $clog2(MAX_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 enable,
  input  logic [1:0]           cfgWidth,
  input  logic                 cfgFill24,
  input  logic                 cfgWsPol,
  input  logic [SLOT_W-1:0]    cfgSlotLast,
  input  logic [MAX_SLOTS-1:0] cfgSlotEn,
  input  logic                 cfgSkipMask,
  input  logic                 cfgMono,
  input  logic                 cfgMonoFirst,
  input  logic                 cfgMonoEqual,
  input  logic                 inValid,
  output logic                 inReady,
  output logic                 bckOut,
  output logic                 wsOut,
  output logic                 underflow,
  output ctrlStrobe_t          st
);
  localparam int DIV_W = (BCK_HALF > 1) ? $clog2(BCK_HALF) : 1;

  logic [DIV_W-1:0]  divCnt;
  logic              bckQ, wsQ, underflowQ;
  logic [SLOT_W-1:0] slotIdx, lastSlot;
  logic [5:0]        bitIdx, slotLen;
  logic [SLOT_W:0]   frameSlots, dblIdx;
  logic              halfDone, tick, slotStart, needWord, isLeft, validHere;

  assign slotLen    = slotBits(cfgWidth, cfgFill24);
  assign halfDone   = (divCnt == DIV_W'(BCK_HALF - 1));
  assign tick       = enable && halfDone && bckQ;           // falling edge of BCK
  assign lastSlot   = cfgMono ? SLOT_W'(1) : cfgSlotLast;
  assign frameSlots = {1'b0, lastSlot} + (SLOT_W + 1)'(1);
  assign dblIdx     = {slotIdx, 1'b0};
  assign isLeft     = dblIdx < frameSlots;
  assign slotStart  = tick && (bitIdx == 6'd0);
  assign needWord   = cfgMono ? (slotIdx == '0) : (cfgSlotEn[slotIdx] || cfgSkipMask);
  assign validHere  = ((slotIdx == '0) == cfgMonoFirst);
  assign inReady    = slotStart && needWord;

  always_comb begin
    st          = '0;
    st.flush    = !enable;
    st.bitTick  = tick;
    st.loadSlot = slotStart;
    st.wordOk   = inValid;
    st.capHeld  = slotStart && cfgMono && (slotIdx == '0);
    if (cfgMono) begin
      if (validHere || cfgMonoEqual) st.src = (slotIdx == '0) ? SRC_INPUT : SRC_HELD;
      else                           st.src = SRC_CONST;
    end else begin
      st.src = cfgSlotEn[slotIdx] ? SRC_INPUT : SRC_ZERO;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0; bckQ <= 1'b0; wsQ <= 1'b0; underflowQ <= 1'b0;
      slotIdx <= '0; bitIdx <= '0;
    end else if (!enable) begin
      divCnt <= '0; bckQ <= 1'b0; wsQ <= cfgWsPol; underflowQ <= 1'b0;
      slotIdx <= '0; bitIdx <= '0;
    end else begin
      underflowQ <= slotStart && needWord && !inValid;
      if (halfDone) begin
        divCnt <= '0;
        bckQ   <= ~bckQ;
      end else begin
        divCnt <= divCnt + DIV_W'(1);
      end
      if (tick) begin
        wsQ <= isLeft ? cfgWsPol : ~cfgWsPol;
        if (bitIdx >= slotLen - 6'd1) begin
          bitIdx  <= '0;
          slotIdx <= (slotIdx >= lastSlot) ? '0 : slotIdx + SLOT_W'(1);
        end else begin
          bitIdx <= bitIdx + 6'd1;
        end
      end
    end
  end

  assign bckOut    = bckQ;
  assign wsOut     = wsQ;
  assign underflow = underflowQ;
endmodule

// File: rtl/i2s_tx_dpath.sv
module i2s_tx_dpath
  import i2s_tx_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       st,
  input  logic [1:0]        cfgWidth,
  input  logic              cfgFill24,
  input  logic              cfgLeftAlign,
  input  logic              cfgLsbFirst,
  input  logic [DATA_W-1:0] cfgConst,
  input  logic [DATA_W-1:0] inData,
  output logic              sdOut
);
  logic [DATA_W-1:0] heldQ, shReg, raw, masked, revd, topAl, slotWord;
  logic [5:0]        smpLen, slotLen;
  logic [6:0]        padTop;
  logic              prevBit, sdQ;

  assign smpLen  = sampleBits(cfgWidth);
  assign slotLen = slotBits(cfgWidth, cfgFill24);
  assign padTop  = 7'(DATA_W) - {1'b0, smpLen};

  always_comb begin
    case (st.src)
      SRC_INPUT: raw = st.wordOk ? inData : '0;
      SRC_HELD:  raw = heldQ;
      SRC_CONST: raw = cfgConst;
      default:   raw = '0;
    endcase
  end

  assign masked = raw & ({DATA_W{1'b1}} >> padTop);

  // first bit to send always sits in the MSB of the slot word
  always_comb begin
    for (int i = 0; i < DATA_W; i++) revd[i] = masked[DATA_W-1-i];
  end

  assign topAl    = cfgLsbFirst ? revd : (masked << padTop);
  assign slotWord = cfgLeftAlign ? topAl : (topAl >> (slotLen - smpLen));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldQ <= '0; shReg <= '0; prevBit <= 1'b0; sdQ <= 1'b0;
    end else if (st.flush) begin
      heldQ <= '0; shReg <= '0; prevBit <= 1'b0; sdQ <= 1'b0;
    end else if (st.bitTick) begin
      if (st.loadSlot) begin
        prevBit <= slotWord[DATA_W-1];
        shReg   <= slotWord << 1;
      end else begin
        prevBit <= shReg[DATA_W-1];
        shReg   <= shReg << 1;
      end
      sdQ <= prevBit;
      if (st.capHeld) heldQ <= st.wordOk ? inData : '0;
    end
  end

  assign sdOut = sdQ;
endmodule

// File: rtl/i2s_tx_serializer.sv
module i2s_tx_serializer
  import i2s_tx_pkg::*;
#(
  parameter int BCK_HALF  = 2,
  parameter int MAX_SLOTS = 16,
  parameter int DATA_W    = 32,
  localparam int SLOT_W   = $clog2(MAX_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 enable,
  input  logic [1:0]           cfgWidth,
  input  logic                 cfgFill24,
  input  logic                 cfgLeftAlign,
  input  logic                 cfgLsbFirst,
  input  logic                 cfgWsPol,
  input  logic [SLOT_W-1:0]    cfgSlotLast,
  input  logic [MAX_SLOTS-1:0] cfgSlotEn,
  input  logic                 cfgSkipMask,
  input  logic                 cfgMono,
  input  logic                 cfgMonoFirst,
  input  logic                 cfgMonoEqual,
  input  logic [DATA_W-1:0]    cfgConst,
  input  logic                 inValid,
  input  logic [DATA_W-1:0]    inData,
  output logic                 inReady,
  output logic                 bckOut,
  output logic                 wsOut,
  output logic                 sdOut,
  output logic                 underflow
);
  ctrlStrobe_t strobe;

  i2s_tx_ctrl #(.BCK_HALF(BCK_HALF), .MAX_SLOTS(MAX_SLOTS)) ctrl_i (
    .clk(clk), .rstN(rstN), .enable(enable),
    .cfgWidth(cfgWidth), .cfgFill24(cfgFill24), .cfgWsPol(cfgWsPol),
    .cfgSlotLast(cfgSlotLast), .cfgSlotEn(cfgSlotEn), .cfgSkipMask(cfgSkipMask),
    .cfgMono(cfgMono), .cfgMonoFirst(cfgMonoFirst), .cfgMonoEqual(cfgMonoEqual),
    .inValid(inValid), .inReady(inReady), .bckOut(bckOut), .wsOut(wsOut),
    .underflow(underflow), .st(strobe)
  );

  i2s_tx_dpath #(.DATA_W(DATA_W)) dpath_i (
    .clk(clk), .rstN(rstN), .st(strobe),
    .cfgWidth(cfgWidth), .cfgFill24(cfgFill24), .cfgLeftAlign(cfgLeftAlign),
    .cfgLsbFirst(cfgLsbFirst), .cfgConst(cfgConst), .inData(inData), .sdOut(sdOut)
  );
endmodule

// File: rtl/i2s_tx_checker.sv
module i2s_tx_checker (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic inValid,
  input logic inReady,
  input logic bckOut,
  input logic wsOut,
  input logic sdOut,
  input logic underflow
);
  p_ws_on_fall_r2: assert property (@(posedge clk) disable iff (!rstN)
    (enable && $past(enable) && !$stable(wsOut)) |-> $fell(bckOut));

  p_sd_on_fall_r2: assert property (@(posedge clk) disable iff (!rstN)
    (enable && $past(enable) && !$stable(sdOut)) |-> $fell(bckOut));

  p_bck_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !bckOut);

  p_ready_single_r12: assert property (@(posedge clk) disable iff (!rstN)
    inReady |=> !inReady);

  p_underflow_cause_r11: assert property (@(posedge clk) disable iff (!rstN)
    underflow |-> $past(inReady && !inValid));
endmodule

bind i2s_tx_serializer i2s_tx_checker chk_i (
  .clk(clk), .rstN(rstN), .enable(enable), .inValid(inValid), .inReady(inReady),
  .bckOut(bckOut), .wsOut(wsOut), .sdOut(sdOut), .underflow(underflow)
);

// File: tb/i2s_tx_serializer_tb_top.sv
`timescale 1ns/1ps
module i2s_tx_serializer_tb_top;
  localparam int HALF = 4;

  logic        clk = 1'b0, rstN = 1'b0, enable = 1'b0;
  logic [1:0]  cfgWidth = 2'b00;
  logic        cfgFill24 = 0, cfgLeftAlign = 0, cfgLsbFirst = 0, cfgWsPol = 0;
  logic [3:0]  cfgSlotLast = 4'd1;
  logic [15:0] cfgSlotEn = 16'h0003;
  logic        cfgSkipMask = 0, cfgMono = 0, cfgMonoFirst = 0, cfgMonoEqual = 0;
  logic [31:0] cfgConst = '0;
  logic        inValid, inReady, bckOut, wsOut, sdOut, underflow;
  logic [31:0] inData;

  logic [31:0] words [0:63];
  int          nWords = 0, rdIdx = 0;
  logic        rdClr = 0, capClr = 0;
  logic        capWs [0:511];
  logic        capSd [0:511];
  logic        expWs [0:511];
  logic        expBit[0:511];
  int          capN = 0, ufCnt = 0, periodBad = 0, cyc = 0, lastRise = 0;
  logic        prevBck = 0, seenFall = 0;
  int          expN, expPops;
  int          checks = 0, errors = 0;

  always #4 clk = ~clk;

  assign inValid = rdIdx < nWords;
  assign inData  = inValid ? words[rdIdx[5:0]] : 32'h0;

  i2s_tx_serializer #(.BCK_HALF(HALF)) dut_i (
    .clk(clk), .rstN(rstN), .enable(enable), .cfgWidth(cfgWidth), .cfgFill24(cfgFill24),
    .cfgLeftAlign(cfgLeftAlign), .cfgLsbFirst(cfgLsbFirst), .cfgWsPol(cfgWsPol),
    .cfgSlotLast(cfgSlotLast), .cfgSlotEn(cfgSlotEn), .cfgSkipMask(cfgSkipMask),
    .cfgMono(cfgMono), .cfgMonoFirst(cfgMonoFirst), .cfgMonoEqual(cfgMonoEqual),
    .cfgConst(cfgConst), .inValid(inValid), .inData(inData), .inReady(inReady),
    .bckOut(bckOut), .wsOut(wsOut), .sdOut(sdOut), .underflow(underflow)
  );

  always @(posedge clk) begin
    if (rdClr) rdIdx <= 0;
    else if (inValid && inReady) rdIdx <= rdIdx + 1;
  end

  // capture on rising BCK, sampled between clock edges
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (capClr) begin
      capN = 0; ufCnt = 0; periodBad = 0; seenFall = 0;
    end else begin
      if (underflow) ufCnt = ufCnt + 1;
      if (prevBck && !bckOut) seenFall = 1;
      if (enable && !prevBck && bckOut && seenFall && capN < 512) begin
        if (capN > 0 && (cyc - lastRise) != 2 * HALF) periodBad = periodBad + 1;
        capWs[capN] = wsOut; capSd[capN] = sdOut; capN = capN + 1;
        lastRise = cyc;
      end
    end
    prevBck = bckOut;
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, what, act, act, exp, exp);
    end
  endtask

  // expected stream built from the requirements
  task automatic buildExp(input int nFrames);
    int pos = 0, wIdx = 0;
    for (int f = 0; f < nFrames; f++) begin
      int nSl = cfgMono ? 2 : int'(cfgSlotLast) + 1;
      logic [31:0] held = 0;
      for (int s = 0; s < nSl; s++) begin
        logic [31:0] w = 0, smp;
        int W = (cfgWidth == 0) ? 16 : (cfgWidth == 1) ? 24 : 32;
        int L = (cfgWidth == 0) ? 16 : (cfgWidth == 1 && !cfgFill24) ? 24 : 32;
        logic wsLvl = (2 * s < nSl) ? cfgWsPol : !cfgWsPol;
        if (cfgMono) begin
          if (s == 0) begin
            if (wIdx < nWords) begin w = words[wIdx]; wIdx++; end
            held = w;
          end
          smp = ((((s == 0) == cfgMonoFirst)) || cfgMonoEqual) ? held : cfgConst;
        end else begin
          if (cfgSlotEn[s] || cfgSkipMask) begin
            if (wIdx < nWords) begin w = words[wIdx]; wIdx++; end
          end
          smp = cfgSlotEn[s] ? w : 32'h0;
        end
        for (int b = 0; b < L; b++) begin
          int idx = cfgLeftAlign ? b : b - (L - W);
          expWs[pos]  = wsLvl;
          expBit[pos] = (idx >= 0 && idx < W) ? smp[cfgLsbFirst ? idx : W - 1 - idx] : 1'b0;
          pos++;
        end
      end
    end
    expN = pos; expPops = wIdx;
  endtask

  task automatic runCase(input string name, input string reqWs, input string reqSd, input int nFrames);
    int t = 0, wsBad = -1, sdBad = -1;
    buildExp(nFrames);
    @(negedge clk); rdClr = 1; capClr = 1;
    repeat (3) @(negedge clk);
    rdClr = 0; capClr = 0; enable = 1;
    while (capN < expN && t < 40000) begin @(negedge clk); t++; end
    enable = 0;
    repeat (3) @(negedge clk);
    check(capN >= expN, reqWs, {name, " bits captured"}, capN, expN);
    for (int k = 0; k < expN; k++) begin
      if (wsBad < 0 && capWs[k] !== expWs[k]) wsBad = k;
      if (sdBad < 0 && capSd[k] !== ((k == 0) ? 1'b0 : expBit[k-1])) sdBad = k;
    end
    check(wsBad < 0, reqWs, {name, " ws first mismatch index"}, wsBad, -1);
    check(sdBad < 0, reqSd, {name, " sd first mismatch index"}, sdBad, -1);
    check(rdIdx == expPops, "R12", {name, " words accepted"}, rdIdx, expPops);
  endtask

  task automatic setBase();
    cfgWidth = 0; cfgFill24 = 0; cfgLeftAlign = 0; cfgLsbFirst = 0; cfgWsPol = 0;
    cfgSlotLast = 1; cfgSlotEn = 16'h0003; cfgSkipMask = 0;
    cfgMono = 0; cfgMonoFirst = 0; cfgMonoEqual = 0; cfgConst = 0;
    for (int i = 0; i < 64; i++) words[i] = 32'h9E37_79B9 * (i + 1) ^ (i << 7);
    nWords = 64;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(bckOut == 0 && wsOut == 0 && sdOut == 0, "R1", "outputs in reset", {bckOut, wsOut, sdOut}, 0);
    check(underflow == 0 && inReady == 0, "R1", "flags in reset", {underflow, inReady}, 0);
  endtask

  task automatic t_stereo16();
    setBase();
    runCase("stereo16 msb pol0", "R3", "R4", 3);
    check(periodBad == 0, "R2", "bck period deviations", periodBad, 0);
  endtask

  task automatic t_stereo32Lsb();
    setBase(); cfgWidth = 2; cfgLsbFirst = 1; cfgWsPol = 1;
    runCase("stereo32 lsb pol1", "R3", "R5", 2);
  endtask

  task automatic t_pad24();
    setBase(); cfgWidth = 1; cfgFill24 = 1; cfgLeftAlign = 1;
    runCase("24 in 32 left", "R4", "R6", 2);
    setBase(); cfgWidth = 1; cfgFill24 = 1; cfgLeftAlign = 0; cfgLsbFirst = 1;
    runCase("24 in 32 right lsb", "R4", "R6", 2);
    setBase(); cfgWidth = 1; cfgFill24 = 0;
    runCase("24 in 24", "R4", "R4", 2);
  endtask

  task automatic t_tdm();
    setBase(); cfgSlotLast = 3; cfgSlotEn = 16'h000B; cfgSkipMask = 0;
    runCase("tdm4 slot2 off noskip", "R7", "R8", 2);
    setBase(); cfgSlotLast = 3; cfgSlotEn = 16'h000B; cfgSkipMask = 1;
    runCase("tdm4 slot2 off skip", "R7", "R8", 2);
    setBase(); cfgSlotLast = 15; cfgSlotEn = 16'hA5C3; cfgWsPol = 1;
    runCase("tdm16 sparse", "R7", "R7", 1);
  endtask

  task automatic t_mono();
    setBase(); cfgMono = 1; cfgMonoFirst = 1; cfgMonoEqual = 1; cfgSlotLast = 7;
    runCase("mono first equal", "R9", "R10", 2);
    setBase(); cfgMono = 1; cfgMonoFirst = 0; cfgMonoEqual = 0; cfgWidth = 2;
    cfgConst = 32'h00C0_FFEE;
    runCase("mono second const", "R9", "R10", 2);
  endtask

  task automatic t_underflow();
    setBase(); nWords = 0;
    runCase("empty stream", "R11", "R11", 2);
    check(ufCnt == 4, "R11", "underflow pulses", ufCnt, 4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    setBase();
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1;
    repeat (3) @(negedge clk);
    t_stereo16();
    t_stereo32Lsb();
    t_pad24();
    t_tdm();
    t_mono();
    t_underflow();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule